// File: doc/BRIEF.md
# Clock Recovery Training Sequencer

This block runs the first phase of serial link training. On a start pulse it latches the link configuration and issues a series of commands on a generic command port. First it writes the link setup: the bandwidth code, the lane count and, when the sink uses a rate table, a rate-select byte. It then writes a spread/coding pair. Next it clears the per-lane drive bytes and writes training pattern 1 with scrambling disabled.

After that it loops. Each pass waits a programmable number of cycles, reads the link status and then does one of three things: it finishes, it restarts from zero drive, or it writes new drive levels. The new drive byte comes from an external combiner that reduces the status to a single setting.

Two give-up counters bound the loop. One counts full restarts, taken when every active lane already shows the maximum-swing flag. The other counts passes in which lane 0 keeps the same swing. The result is reported on done, pass and fail.

Top module: `cr_train_seq`

## Requirements
- R1: After reset, done, pass, fail and the command request are all low.
- R2: On start the block issues, in order:
  - op 0, length 2: the bandwidth code, then the lane count with bit 7 set when the sink supports enhanced framing.
  - op 1, length 1: the rate-select byte. This command is issued only when the rate-table input is high.
  - op 2, length 2: byte 0x00, then byte 0x01.
- R3: A pattern write is op 3, length lanes+1. Byte 0 is 0x21 (pattern 1 with the scrambling-disable bit 5). One lane byte per active lane follows. The first pattern write carries all-zero lane bytes, and if it is refused the block ends with fail.
- R4: Each pass waits at least the programmed delay in cycles after the previous command's acknowledge, then issues a status read (op 4... see R8 for op 4; the status read is op 5, length 0). A refused status read ends with fail.
- R5: When every active lane's lock bit is set, the block ends with pass. Lane i uses bit i of the lock input, and bits of inactive lanes are ignored.
- R6: A lane byte holds the swing in bits 1:0 and the maximum-swing flag in bit 2. When every active lane's byte has the flag set, the full-retry count increments. At 5 the block ends with fail. Below 5 it clears all lane bytes, clears the same-swing count and rewrites the pattern (R3 format); the result of that rewrite is ignored.
- R7: Otherwise, if lane 0's current swing equals the recorded swing, the same-swing count increments, and at 5 the block ends with fail. If the swings differ, the count clears. The recorded swing is 0xFF after start, so the first pass never matches.
- R8: If the pass has not ended, the block records lane 0's swing and loads the drive input (sampled with the status acknowledge) into every lane byte. It then writes op 4 with length equal to the lane count, one byte per active lane. A refused write ends with fail.
- R9: Done stays high until the next start, and pass and fail are never high together.
- R10: A command request, with its op, length and data, stays unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle or done |
| bw_code_i | input | 8 | Bandwidth code |
| lane_cnt_i | input | LCW | Active lane count |
| enh_cap_i | input | 1 | Sink supports enhanced framing |
| rate_tab_i | input | 1 | Sink uses a rate table |
| rate_sel_i | input | 8 | Rate-select byte |
| delay_i | input | DW | Wait cycles before each status read |
| drv_set_i | input | 8 | Combined drive byte from the combiner |
| cmd_req_o | output | 1 | Command request |
| cmd_op_o | output | 3 | Command op code |
| cmd_len_o | output | LENW | Bytes in the command |
| cmd_data_o | output | (LANES+1)*8 | Command bytes, byte 0 in bits 7:0 |
| cmd_ack_i | input | 1 | Command acknowledge (one cycle) |
| cmd_ok_i | input | 1 | Command succeeded, valid with the acknowledge |
| lock_i | input | LANES | Per-lane lock bits, valid with a status acknowledge |
| done_o | output | 1 | Training finished |
| pass_o | output | 1 | Training passed |
| fail_o | output | 1 | Training failed |

## Verification
The assertions check the invariants on every cycle:
- the result flags are exclusive and consistent with done, and done is held;
- a request keeps its op and data until acknowledged;
- the wait counter decrements without skipping, and no status read is issued before it expires;
- both retry counters stay within their limits.

Only the bench scenarios can show the sequences themselves:
- the exact byte order of the setup and pattern writes;
- the pass on which each give-up counter trips (7 status reads for the same-swing limit, 10 for the full-retry limit);
- that locks from inactive lanes are ignored.

// File: rtl/cr_pkg.sv
package cr_pkg;

    typedef enum logic [2:0] {
        OP_CFG    = 3'd0,
        OP_RATE   = 3'd1,
        OP_SPREAD = 3'd2,
        OP_PAT    = 3'd3,
        OP_LANES  = 3'd4,
        OP_STAT   = 3'd5
    } cr_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CFG,
        S_RATE,
        S_SPREAD,
        S_PAT0,
        S_WAIT,
        S_STAT,
        S_PATR,
        S_LANES,
        S_DONE
    } cr_state_e;

    localparam logic [7:0] PAT1_NOSCR   = 8'h21;
    localparam logic [7:0] ENH_FRAME    = 8'h80;
    localparam logic [7:0] CODE_8B10B   = 8'h01;
    localparam logic [7:0] SWING_UNSEEN = 8'hFF;
    localparam int         MAXSW_BIT    = 2;

endpackage

// File: rtl/cr_retry_ctr.sv
module cr_retry_ctr #(
    parameter int LIMIT = 5,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic          hit,
    output logic [CW-1:0] cnt
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && cnt_q != CW'(LIMIT))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = inc && !clr && (cnt_q == CW'(LIMIT - 1));
    assign cnt = cnt_q;

    // R6 / R7: give-up counters never pass their limit
    a_r6_r7_ctr_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT));

endmodule

// File: rtl/cr_delay_tmr.sv
module cr_delay_tmr #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic          expired
);

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R4: wait counter steps down by one each cycle when not reloaded
    a_r4_tmr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/cr_lane_all.sv
module cr_lane_all #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] active,
    input  logic [LANES-1:0] flag,
    output logic             all_set
);

    logic [LANES-1:0] ok;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign ok[g] = flag[g] | ~active[g];
    end

    assign all_set = (&ok) && (|active);

endmodule

// File: rtl/cr_train_seq.sv
module cr_train_seq
    import cr_pkg::*;
#(
    parameter int  LANES     = 4,
    parameter int  DW        = 16,
    parameter int  FULL_MAX  = 5,
    parameter int  SAME_MAX  = 5,
    localparam int LCW  = $clog2(LANES + 1),
    localparam int LENW = $clog2(LANES + 2),
    localparam int BW   = (LANES + 1) * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       bw_code_i,
    input  logic [LCW-1:0]   lane_cnt_i,
    input  logic             enh_cap_i,
    input  logic             rate_tab_i,
    input  logic [7:0]       rate_sel_i,
    input  logic [DW-1:0]    delay_i,
    input  logic [7:0]       drv_set_i,
    output logic             cmd_req_o,
    output logic [2:0]       cmd_op_o,
    output logic [LENW-1:0]  cmd_len_o,
    output logic [BW-1:0]    cmd_data_o,
    input  logic             cmd_ack_i,
    input  logic             cmd_ok_i,
    input  logic [LANES-1:0] lock_i,
    output logic             done_o,
    output logic             pass_o,
    output logic             fail_o
);

    typedef struct packed {
        cr_state_e              st;
        logic [7:0]             bw;
        logic [LCW-1:0]         lanes;
        logic                   enh;
        logic                   use_rt;
        logic [7:0]             rsel;
        logic [DW-1:0]          dly;
        logic [LANES-1:0][7:0]  set;
        logic [7:0]             prev_sw;
        logic                   pass;
        logic                   fail;
    } seq_t;

    seq_t d, q;

    logic [LANES-1:0] active, maxsw;
    logic             lock_all, max_all;
    logic             tmr_load, tmr_expired;
    logic             full_inc, full_hit, same_inc, same_clr, same_hit, ctr_clr;
    logic [$clog2(FULL_MAX+1)-1:0] full_cnt;
    logic [$clog2(SAME_MAX+1)-1:0] same_cnt;
    logic             ack;

    assign ack = cmd_ack_i && cmd_req_o;

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign active[g] = (LCW'(g) < q.lanes);
        assign maxsw[g]  = q.set[g][MAXSW_BIT];
    end

    cr_lane_all #(.LANES(LANES)) i_lock_all (
        .active (active),
        .flag   (lock_i),
        .all_set(lock_all)
    );

    cr_lane_all #(.LANES(LANES)) i_max_all (
        .active (active),
        .flag   (maxsw),
        .all_set(max_all)
    );

    cr_delay_tmr #(.DW(DW)) i_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(q.dly),
        .expired (tmr_expired)
    );

    cr_retry_ctr #(.LIMIT(FULL_MAX)) i_full_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ctr_clr),
        .inc  (full_inc),
        .hit  (full_hit),
        .cnt  (full_cnt)
    );

    cr_retry_ctr #(.LIMIT(SAME_MAX)) i_same_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ctr_clr | same_clr),
        .inc  (same_inc),
        .hit  (same_hit),
        .cnt  (same_cnt)
    );

    // Command port outputs, decoded from the registered state
    always_comb begin
        cmd_req_o  = 1'b0;
        cmd_op_o   = OP_STAT;
        cmd_len_o  = '0;
        cmd_data_o = '0;
        unique case (q.st)
            S_CFG: begin
                cmd_req_o        = 1'b1;
                cmd_op_o         = OP_CFG;
                cmd_len_o        = LENW'(2);
                cmd_data_o[7:0]  = q.bw;
                cmd_data_o[15:8] = 8'(q.lanes) | (q.enh ? ENH_FRAME : 8'h00);
            end
            S_RATE: begin
                cmd_req_o       = 1'b1;
                cmd_op_o        = OP_RATE;
                cmd_len_o       = LENW'(1);
                cmd_data_o[7:0] = q.rsel;
            end
            S_SPREAD: begin
                cmd_req_o        = 1'b1;
                cmd_op_o         = OP_SPREAD;
                cmd_len_o        = LENW'(2);
                cmd_data_o[15:8] = CODE_8B10B;
            end
            S_PAT0, S_PATR: begin
                cmd_req_o       = 1'b1;
                cmd_op_o        = OP_PAT;
                cmd_len_o       = LENW'(q.lanes) + 1'b1;
                cmd_data_o[7:0] = PAT1_NOSCR;
                for (int i = 0; i < LANES; i++)
                    if (active[i]) cmd_data_o[8*(i+1) +: 8] = q.set[i];
            end
            S_LANES: begin
                cmd_req_o = 1'b1;
                cmd_op_o  = OP_LANES;
                cmd_len_o = LENW'(q.lanes);
                for (int i = 0; i < LANES; i++)
                    if (active[i]) cmd_data_o[8*i +: 8] = q.set[i];
            end
            S_STAT: begin
                cmd_req_o = 1'b1;
                cmd_op_o  = OP_STAT;
            end
            default: ;
        endcase
    end

    // Next-state computation
    always_comb begin
        d        = q;
        full_inc = 1'b0;
        same_inc = 1'b0;
        same_clr = 1'b0;
        ctr_clr  = 1'b0;
        unique case (q.st)
            S_IDLE, S_DONE: begin
                if (start_i) begin
                    d.st      = S_CFG;
                    d.bw      = bw_code_i;
                    d.lanes   = lane_cnt_i;
                    d.enh     = enh_cap_i;
                    d.use_rt  = rate_tab_i;
                    d.rsel    = rate_sel_i;
                    d.dly     = delay_i;
                    d.set     = '0;
                    d.prev_sw = SWING_UNSEEN;
                    d.pass    = 1'b0;
                    d.fail    = 1'b0;
                    ctr_clr   = 1'b1;
                end
            end
            S_CFG:    if (ack) d.st = q.use_rt ? S_RATE : S_SPREAD;
            S_RATE:   if (ack) d.st = S_SPREAD;
            S_SPREAD: if (ack) d.st = S_PAT0;
            S_PAT0: begin
                if (ack) begin
                    if (cmd_ok_i) d.st = S_WAIT;
                    else begin d.st = S_DONE; d.fail = 1'b1; end
                end
            end
            S_WAIT:   if (tmr_expired) d.st = S_STAT;
            S_STAT: begin
                if (ack) begin
                    if (!cmd_ok_i) begin
                        d.st = S_DONE; d.fail = 1'b1;
                    end else if (lock_all) begin
                        d.st = S_DONE; d.pass = 1'b1;
                    end else if (max_all) begin
                        full_inc = 1'b1;
                        if (full_hit) begin
                            d.st = S_DONE; d.fail = 1'b1;
                        end else begin
                            d.set    = '0;
                            same_clr = 1'b1;
                            d.st     = S_PATR;
                        end
                    end else begin
                        if ({6'd0, q.set[0][1:0]} == q.prev_sw) same_inc = 1'b1;
                        else                                    same_clr = 1'b1;
                        if (same_inc && same_hit) begin
                            d.st = S_DONE; d.fail = 1'b1;
                        end else begin
                            d.prev_sw = {6'd0, q.set[0][1:0]};
                            for (int i = 0; i < LANES; i++) d.set[i] = drv_set_i;
                            d.st = S_LANES;
                        end
                    end
                end
            end
            S_PATR:   if (ack) d.st = S_WAIT;
            S_LANES: begin
                if (ack) begin
                    if (cmd_ok_i) d.st = S_WAIT;
                    else begin d.st = S_DONE; d.fail = 1'b1; end
                end
            end
            default:  d.st = S_IDLE;
        endcase
    end

    assign tmr_load = (d.st == S_WAIT) && (q.st != S_WAIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= S_IDLE;
            q.prev_sw <= SWING_UNSEEN;
        end else begin
            q <= d;
        end
    end

    assign done_o = (q.st == S_DONE);
    assign pass_o = q.pass;
    assign fail_o = q.fail;

    // R9: outcome flags are exclusive
    a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o));
    // R9: done always carries exactly one outcome
    a_r9_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pass_o ^ fail_o));
    // R9: done holds until the next start
    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(pass_o) && $stable(fail_o)));
    // R10: request and its contents stay until acknowledged
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req_o && !cmd_ack_i) |=> (cmd_req_o && $stable(cmd_op_o)
                                       && $stable(cmd_len_o) && $stable(cmd_data_o)));
    // R4: no status read while the wait counter still runs
    a_r4_stat_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req_o && cmd_op_o == OP_STAT) |-> tmr_expired);
    // R5: a pass only follows an accepted status read
    a_r5_pass_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass_o) |-> $past(cmd_ack_i && cmd_ok_i && cmd_op_o == OP_STAT));

endmodule

// File: tb/test_cr_train_seq.sv
module test_cr_train_seq;
    import cr_pkg::*;

    localparam int LANES = 4;
    localparam int LCW   = $clog2(LANES + 1);
    localparam int LENW  = $clog2(LANES + 2);
    localparam int BW    = (LANES + 1) * 8;

    typedef struct {
        logic [2:0]       op;
        int               len;
        logic [BW-1:0]    data;
        bit               ok;
        logic [LANES-1:0] lock;
        logic [7:0]       drv;
        string            tag;
    } item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [7:0]       bw_code_i = '0;
    logic [LCW-1:0]   lane_cnt_i = '0;
    logic             enh_cap_i = 1'b0;
    logic             rate_tab_i = 1'b0;
    logic [7:0]       rate_sel_i = '0;
    logic [15:0]      delay_i = '0;
    logic [7:0]       drv_set_i = '0;
    logic             cmd_req_o;
    logic [2:0]       cmd_op_o;
    logic [LENW-1:0]  cmd_len_o;
    logic [BW-1:0]    cmd_data_o;
    logic             cmd_ack_i = 1'b0;
    logic             cmd_ok_i = 1'b0;
    logic [LANES-1:0] lock_i = '0;
    logic             done_o, pass_o, fail_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_ack = 0;
    item_t q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cr_train_seq #(.LANES(LANES)) i_cr_train_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .bw_code_i(bw_code_i),
        .lane_cnt_i(lane_cnt_i), .enh_cap_i(enh_cap_i), .rate_tab_i(rate_tab_i),
        .rate_sel_i(rate_sel_i), .delay_i(delay_i), .drv_set_i(drv_set_i),
        .cmd_req_o(cmd_req_o), .cmd_op_o(cmd_op_o), .cmd_len_o(cmd_len_o),
        .cmd_data_o(cmd_data_o), .cmd_ack_i(cmd_ack_i), .cmd_ok_i(cmd_ok_i),
        .lock_i(lock_i), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
    );

    task automatic check(input bit cond, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] op, input int len, input logic [BW-1:0] data,
                        input bit ok, input logic [LANES-1:0] lock,
                        input logic [7:0] drv, input string tag);
        item_t it;
        it.op = op; it.len = len; it.data = data; it.ok = ok;
        it.lock = lock; it.drv = drv; it.tag = tag;
        q.push_back(it);
    endtask

    // R2 and R3: setup commands and the first zero-drive pattern write
    task automatic push_prep(input logic [7:0] bw, input int lanes, input bit enh,
                             input bit rt, input logic [7:0] rs, input bit pat_ok);
        logic [7:0] lb;
        lb = 8'(lanes) | (enh ? 8'h80 : 8'h00);
        push(3'd0, 2, BW'({lb, bw}), 1'b1, '0, '0, "R2 config");
        if (rt) push(3'd1, 1, BW'(rs), 1'b1, '0, '0, "R2 rate select");
        push(3'd2, 2, BW'(16'h0100), 1'b1, '0, '0, "R2 spread/coding");
        push(3'd3, lanes + 1, BW'(8'h21), pat_ok, '0, '0, "R3 initial pattern");
    endtask

    function automatic logic [BW-1:0] lane_bytes(input logic [7:0] b, input int lanes,
                                                 input int off);
        logic [BW-1:0] r;
        r = '0;
        for (int i = 0; i < lanes; i++) r[8*(i+off) +: 8] = b;
        return r;
    endfunction

    // Scoreboard monitor: acts as responder, pops and compares each request
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cmd_req_o) begin
                if (q.size() == 0) begin
                    check(1'b0, "R10 unexpected command", 64'(cmd_op_o), 64'hF);
                    cmd_ok_i = 1'b0;
                end else begin
                    item_t it;
                    bit    same;
                    it = q.pop_front();
                    same = (cmd_op_o == it.op) && (int'(cmd_len_o) == it.len);
                    for (int i = 0; i < it.len; i++)
                        if (cmd_data_o[8*i +: 8] !== it.data[8*i +: 8]) same = 1'b0;
                    check(same, it.tag, {cmd_op_o, 5'd0, 8'(cmd_len_o), cmd_data_o},
                          {it.op, 5'd0, 8'(it.len), it.data});
                    if (it.op == 3'd5)
                        check((cyc - last_ack) >= int'(delay_i), "R4 wait before status",
                              64'(cyc - last_ack), 64'(delay_i));
                    cmd_ok_i  = it.ok;
                    lock_i    = it.lock;
                    drv_set_i = it.drv;
                end
                cmd_ack_i = 1'b1;
                @(negedge clk);
                cmd_ack_i = 1'b0;
                last_ack  = cyc;
            end
        end
    end

    task automatic run(input logic [7:0] bw, input int lanes, input bit enh, input bit rt,
                       input logic [7:0] rs, input logic [15:0] dly, input bit exp_pass,
                       input string tag);
        int n;
        @(negedge clk);
        bw_code_i = bw; lane_cnt_i = LCW'(lanes); enh_cap_i = enh;
        rate_tab_i = rt; rate_sel_i = rs; delay_i = dly;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (!done_o) begin
            check(1'b0, {tag, " watchdog"}, 64'(n), 64'd0);
            q.delete();
            rst_n = 1'b0;
            repeat (2) @(negedge clk);
            rst_n = 1'b1;
        end else begin
            check(pass_o == exp_pass && fail_o == !exp_pass, tag,
                  {pass_o, fail_o}, {exp_pass, !exp_pass});
            check(q.size() == 0, {tag, " all commands seen"}, 64'(q.size()), 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!done_o && !pass_o && !fail_o && !cmd_req_o, "R1 reset outputs",
              {done_o, pass_o, fail_o, cmd_req_o}, 4'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!done_o && !cmd_req_o, "R1 idle after reset", {done_o, cmd_req_o}, 2'b0);

        // R5/R8: two lanes, rate table, enhanced framing, pass on second status
        push_prep(8'h14, 2, 1'b1, 1'b1, 8'h03, 1'b1);
        push(3'd5, 0, '0, 1'b1, 4'b0000, 8'h09, "R4 status 1");
        push(3'd4, 2, lane_bytes(8'h09, 2, 0), 1'b1, '0, '0, "R8 lane write");
        push(3'd5, 0, '0, 1'b1, 4'b0011, 8'h00, "R4 status 2");
        run(8'h14, 2, 1'b1, 1'b1, 8'h03, 16'd6, 1'b1, "R5 pass two lanes");
        repeat (20) @(negedge clk);
        check(done_o && pass_o && !cmd_req_o, "R9 done held", {done_o, pass_o}, 2'b11);

        // R5: one lane, inactive lane locks ignored
        push_prep(8'h0A, 1, 1'b0, 1'b0, 8'h00, 1'b1);
        push(3'd5, 0, '0, 1'b1, 4'b1110, 8'h02, "R5 inactive locks ignored");
        push(3'd4, 1, BW'(8'h02), 1'b1, '0, '0, "R8 single lane write");
        push(3'd5, 0, '0, 1'b1, 4'b0001, 8'h00, "R4 status lane0 lock");
        run(8'h0A, 1, 1'b0, 1'b0, 8'h00, 16'd3, 1'b1, "R5 pass one lane");

        // R4: refused status read
        push_prep(8'h0A, 4, 1'b0, 1'b0, 8'h00, 1'b1);
        push(3'd5, 0, '0, 1'b0, 4'b1111, 8'h00, "R4 status refused");
        run(8'h0A, 4, 1'b0, 1'b0, 8'h00, 16'd2, 1'b0, "R4 fail on status");

        // R3: refused initial pattern
        push_prep(8'h1E, 2, 1'b0, 1'b0, 8'h00, 1'b0);
        run(8'h1E, 2, 1'b0, 1'b0, 8'h00, 16'd2, 1'b0, "R3 fail on pattern");

        // R8: refused lane write
        push_prep(8'h0A, 2, 1'b0, 1'b0, 8'h00, 1'b1);
        push(3'd5, 0, '0, 1'b1, 4'b0000, 8'h0A, "R4 status");
        push(3'd4, 2, lane_bytes(8'h0A, 2, 0), 1'b0, '0, '0, "R8 lane write refused");
        run(8'h0A, 2, 1'b0, 1'b0, 8'h00, 16'd1, 1'b0, "R8 fail on lane write");

        // R7: same swing repeated -> give up on the 7th status read
        push_prep(8'h0A, 4, 1'b0, 1'b0, 8'h00, 1'b1);
        for (int k = 0; k < 6; k++) begin
            push(3'd5, 0, '0, 1'b1, 4'b0000, 8'h01, "R7 status");
            push(3'd4, 4, lane_bytes(8'h01, 4, 0), 1'b1, '0, '0, "R7 lane write");
        end
        push(3'd5, 0, '0, 1'b1, 4'b0000, 8'h01, "R7 final status");
        run(8'h0A, 4, 1'b0, 1'b0, 8'h00, 16'd0, 1'b0, "R7 same-swing give up");

        // R6: every lane at max swing -> restart four times, fail on fifth
        push_prep(8'h0A, 2, 1'b0, 1'b0, 8'h00, 1'b1);
        for (int k = 0; k < 4; k++) begin
            push(3'd5, 0, '0, 1'b1, 4'b0000, 8'h07, "R6 status");
            push(3'd4, 2, lane_bytes(8'h07, 2, 0), 1'b1, '0, '0, "R6 lane write");
            push(3'd5, 0, '0, 1'b1, 4'b0000, 8'h07, "R6 status at max");
            push(3'd3, 3, BW'(8'h21), 1'b1, '0, '0, "R6 pattern rewrite zero drive");
        end
        push(3'd5, 0, '0, 1'b1, 4'b0000, 8'h07, "R6 status");
        push(3'd4, 2, lane_bytes(8'h07, 2, 0), 1'b1, '0, '0, "R6 lane write");
        push(3'd5, 0, '0, 1'b1, 4'b0000, 8'h07, "R6 final status");
        run(8'h0A, 2, 1'b0, 1'b0, 8'h00, 16'd2, 1'b0, "R6 full-retry give up");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL global watchdog actual=%0d expected=0", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule